// File: doc/BRIEF.md
# Region-Based Sharer Predictor

This block sits beside a private cache and guesses, at the moment of a miss, which remote core is likely to hold the data. The guess lets the cache send its request directly to that core over a low-latency path while a notice goes to the directory in parallel. The directory remains the only point that orders requests. When the guess is wrong, the directory forwards the request to the real owner and reports the true supplier back, so that the table learns.

Memory is split into 1 KB regions. A small direct-mapped table, indexed by the region number and guarded by a region tag, remembers the core that most recently supplied data anywhere in each region. Beside it, a two-deep list holds the two cores this cache most recently received data from. A tag hit gives the region's core. A tag miss falls back to the most recent sharer. The second sharer is always offered as an alternate target. Lookup is combinational in the cycle of the miss. Writes from data responses and directory corrections take effect on the next clock edge.

Top module: `region_sharer_predictor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the table and the sharer list are empty, so no miss gets a prediction: pred_valid and alt_valid are 0.
- R2: When miss_valid is 0, pred_valid and alt_valid are 0 whatever the table holds.
- R3: The region number is the address shifted right by 10. Its low 4 bits select one of 16 entries and the rest form the tag. If the selected entry is valid and its tag matches, pred_valid is 1 and pred_core is the core stored in that entry.
- R4: On a tag mismatch or an empty entry, pred_core is the most recent sharer with pred_valid 1. If no sharer has been recorded, pred_valid is 0.
- R5: Each data response makes resp_core the most recent sharer. The previous most recent sharer becomes the second sharer, unless it equals resp_core. In that case the list is left unchanged.
- R6: alt_valid is 1 on a miss exactly when a second sharer exists, and alt_core is that second sharer.
- R7: A directory correction writes fix_core into the entry for fix_addr's region and leaves the sharer list unchanged.
- R8: When a response and a correction write the same entry in the same cycle, the correction's core is stored.
- R9: Writes are seen by lookups from the next cycle on. A lookup in the same cycle as a write to its entry sees the old contents.
- R10: Address bits below bit 10 never change which entry is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is being looked up this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| resp_valid | input | 1 | A data response arrived |
| resp_addr | input | 32 | Address the response carries data for |
| resp_core | input | 4 | Core that supplied the response |
| fix_valid | input | 1 | Directory reports the true supplier |
| fix_addr | input | 32 | Address of the corrected request |
| fix_core | input | 4 | True supplier named by the directory |
| pred_valid | output | 1 | A primary target is offered |
| pred_core | output | 4 | Primary predicted supplier |
| alt_valid | output | 1 | An alternate target is offered |
| alt_core | output | 4 | Alternate (second most recent) sharer |

## Verification
The hardest case to reach is a collision inside one entry. Two regions that share the low index bits but differ in tag must evict each other. A response and a correction must also land on the same entry in the same clock. Directed steps build each collision on purpose and check the outcome. A long mixed phase then draws addresses from only three tags and four indices, so aliasing and same-cycle writes come up again and again. The reference model is compared on every cycle of that phase.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_REGION = 2'd1,
    SRC_SHARER = 2'd2
  } pred_src_e;
endpackage

// File: rtl/rsp_region_table.sv
module rsp_region_table #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 10,
  parameter int ENTRIES     = 16,
  parameter int CORE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [CORE_W-1:0] look_core,
  input  logic              wr_a_en,
  input  logic [ADDR_W-1:0] wr_a_addr,
  input  logic [CORE_W-1:0] wr_a_core,
  input  logic              wr_b_en,
  input  logic [ADDR_W-1:0] wr_b_addr,
  input  logic [CORE_W-1:0] wr_b_core
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int REGION_W = ADDR_W - REGION_BITS;
  localparam int TAG_W    = REGION_W - IDX_W;

  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [CORE_W-1:0] core_mem [ENTRIES];
  logic [ENTRIES-1:0] ent_valid;

  logic [REGION_W-1:0] look_region, a_region, b_region;
  logic [IDX_W-1:0]    look_idx, a_idx, b_idx;
  logic [TAG_W-1:0]    look_tag, a_tag, b_tag;

  assign look_region = look_addr[ADDR_W-1:REGION_BITS];
  assign a_region    = wr_a_addr[ADDR_W-1:REGION_BITS];
  assign b_region    = wr_b_addr[ADDR_W-1:REGION_BITS];
  assign look_idx    = look_region[IDX_W-1:0];
  assign a_idx       = a_region[IDX_W-1:0];
  assign b_idx       = b_region[IDX_W-1:0];
  assign look_tag    = look_region[REGION_W-1:IDX_W];
  assign a_tag       = a_region[REGION_W-1:IDX_W];
  assign b_tag       = b_region[REGION_W-1:IDX_W];

  // Storage without reset so it can map to RAM; port B written last wins.
  always_ff @(posedge clk) begin
    if (wr_a_en) begin
      tag_mem[a_idx]  <= a_tag;
      core_mem[a_idx] <= wr_a_core;
    end
    if (wr_b_en) begin
      tag_mem[b_idx]  <= b_tag;
      core_mem[b_idx] <= wr_b_core;
    end
  end

  // Valid bits for each entry, kept apart from the RAM body.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)
        ent_valid[g] <= 1'b0;
      else if ((wr_a_en && a_idx == IDX_W'(g)) || (wr_b_en && b_idx == IDX_W'(g)))
        ent_valid[g] <= 1'b1;
    end
  end

  assign look_hit  = ent_valid[look_idx] && (tag_mem[look_idx] == look_tag);
  assign look_core = core_mem[look_idx];

  assert_resp_visible_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_a_en) && !$past(wr_b_en) &&
     look_region == $past(a_region)) |-> (look_hit && look_core == $past(wr_a_core)))
    else $error("region write not visible next cycle");

  assert_fix_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_a_en && wr_b_en && a_idx == b_idx) |=> (core_mem[$past(b_idx)] == $past(wr_b_core)))
    else $error("correction lost to response on same entry");
endmodule

// File: rtl/rsp_sharer_list.sv
module rsp_sharer_list #(
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [CORE_W-1:0] upd_core,
  output logic              mru_valid,
  output logic [CORE_W-1:0] mru_core,
  output logic              sec_valid,
  output logic [CORE_W-1:0] sec_core
);
  logic shift_now;
  assign shift_now = upd_en && (!mru_valid || upd_core != mru_core);

  always_ff @(posedge clk) begin
    if (rst) begin
      mru_valid <= 1'b0;
      sec_valid <= 1'b0;
      mru_core  <= '0;
      sec_core  <= '0;
    end else if (shift_now) begin
      sec_valid <= mru_valid;
      sec_core  <= mru_core;
      mru_valid <= 1'b1;
      mru_core  <= upd_core;
    end
  end

  assert_empty_R1: assert property (@(posedge clk)
    rst |=> (!mru_valid && !sec_valid))
    else $error("sharer list not cleared by reset");

  assert_newest_R5: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (mru_valid && mru_core == $past(upd_core)))
    else $error("responder not most recent");

  assert_demote_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && mru_valid && upd_core != mru_core) |=> (sec_valid && sec_core == $past(mru_core)))
    else $error("previous sharer not demoted");

  assert_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && mru_valid && upd_core == mru_core) |=> ($stable(sec_core) && $stable(sec_valid)))
    else $error("repeat responder disturbed second sharer");
endmodule

// File: rtl/rsp_select.sv
module rsp_select
  import rsp_pkg::*;
#(
  parameter int CORE_W = 4
) (
  input  logic              miss_valid,
  input  logic              hit,
  input  logic [CORE_W-1:0] hit_core,
  input  logic              mru_valid,
  input  logic [CORE_W-1:0] mru_core,
  input  logic              sec_valid,
  input  logic [CORE_W-1:0] sec_core,
  output logic              pred_valid,
  output logic [CORE_W-1:0] pred_core,
  output logic              alt_valid,
  output logic [CORE_W-1:0] alt_core
);
  pred_src_e src;

  always_comb begin
    if (!miss_valid)    src = SRC_NONE;
    else if (hit)       src = SRC_REGION;
    else if (mru_valid) src = SRC_SHARER;
    else                src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_REGION: begin pred_valid = 1'b1; pred_core = hit_core; end
      SRC_SHARER: begin pred_valid = 1'b1; pred_core = mru_core; end
      default:    begin pred_valid = 1'b0; pred_core = '0;       end
    endcase
  end

  assign alt_valid = miss_valid && sec_valid;
  assign alt_core  = alt_valid ? sec_core : '0;
endmodule

// File: rtl/region_sharer_predictor.sv
module region_sharer_predictor #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 10,
  parameter int ENTRIES     = 16,
  parameter int CORE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              resp_valid,
  input  logic [ADDR_W-1:0] resp_addr,
  input  logic [CORE_W-1:0] resp_core,
  input  logic              fix_valid,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [CORE_W-1:0] fix_core,
  output logic              pred_valid,
  output logic [CORE_W-1:0] pred_core,
  output logic              alt_valid,
  output logic [CORE_W-1:0] alt_core
);
  logic              tbl_hit;
  logic [CORE_W-1:0] tbl_core;
  logic              mru_valid, sec_valid;
  logic [CORE_W-1:0] mru_core, sec_core;

  rsp_region_table #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .ENTRIES(ENTRIES), .CORE_W(CORE_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .look_addr(miss_addr), .look_hit(tbl_hit), .look_core(tbl_core),
    .wr_a_en(resp_valid), .wr_a_addr(resp_addr), .wr_a_core(resp_core),
    .wr_b_en(fix_valid),  .wr_b_addr(fix_addr),  .wr_b_core(fix_core)
  );

  rsp_sharer_list #(.CORE_W(CORE_W)) u_sharers (
    .clk(clk), .rst(rst),
    .upd_en(resp_valid), .upd_core(resp_core),
    .mru_valid(mru_valid), .mru_core(mru_core),
    .sec_valid(sec_valid), .sec_core(sec_core)
  );

  rsp_select #(.CORE_W(CORE_W)) u_select (
    .miss_valid(miss_valid), .hit(tbl_hit), .hit_core(tbl_core),
    .mru_valid(mru_valid), .mru_core(mru_core),
    .sec_valid(sec_valid), .sec_core(sec_core),
    .pred_valid(pred_valid), .pred_core(pred_core),
    .alt_valid(alt_valid), .alt_core(alt_core)
  );

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |-> (!pred_valid && !alt_valid))
    else $error("prediction without a miss");

  assert_nothing_known_R4: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !tbl_hit && !mru_valid) |-> !pred_valid)
    else $error("prediction with empty history");

  assert_alt_R6: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && sec_valid) |-> (alt_valid && alt_core == sec_core))
    else $error("alternate sharer not offered");
endmodule

// File: tb/sim_region_sharer_predictor.sv
`timescale 1ns/1ps
module sim_region_sharer_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0, resp_valid = 1'b0, fix_valid = 1'b0;
  logic [31:0] miss_addr = '0, resp_addr = '0, fix_addr = '0;
  logic [3:0]  resp_core = '0, fix_core = '0;
  logic        pred_valid, alt_valid;
  logic [3:0]  pred_core, alt_core;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit m_v[16];
  int m_tag[16];
  int m_core[16];
  bit mru_v, sec_v;
  int mru, sec;

  always #2 clk = ~clk;

  region_sharer_predictor u0 (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_core(resp_core),
    .fix_valid(fix_valid), .fix_addr(fix_addr), .fix_core(fix_core),
    .pred_valid(pred_valid), .pred_core(pred_core),
    .alt_valid(alt_valid), .alt_core(alt_core)
  );

  function automatic logic [31:0] mk(input int tg, input int ix, input int low);
    return (32'(tg) << 14) | (32'(ix) << 10) | 32'(low);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    mru_v = 0; sec_v = 0; mru = 0; sec = 0;
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(input bit mv, input logic [31:0] ma,
                      input bit rv, input logic [31:0] ra, input int rc,
                      input bit fv, input logic [31:0] fa, input int fc,
                      input string req);
    int reg_n, ix, tg, ep_v, ep_c, ea_v, ea_c;
    @(negedge clk);
    miss_valid = mv; miss_addr = ma;
    resp_valid = rv; resp_addr = ra; resp_core = 4'(rc);
    fix_valid = fv;  fix_addr = fa;  fix_core = 4'(fc);
    #1;
    reg_n = int'(ma >> 10); ix = reg_n % 16; tg = reg_n / 16;
    ep_v = 0; ep_c = 0;
    if (mv) begin
      if (m_v[ix] && m_tag[ix] == tg) begin ep_v = 1; ep_c = m_core[ix]; end
      else if (mru_v) begin ep_v = 1; ep_c = mru; end
    end
    ea_v = (mv && sec_v) ? 1 : 0;
    ea_c = ea_v ? sec : 0;
    if (pred_valid !== 1'(ep_v)) check(req, "pred_valid", int'(pred_valid), ep_v);
    else check(req, "pred_valid", ep_v, ep_v);
    if (ep_v) check(req, "pred_core", int'(pred_core), ep_c);
    if (alt_valid !== 1'(ea_v)) check(req, "alt_valid", int'(alt_valid), ea_v);
    else check(req, "alt_valid", ea_v, ea_v);
    if (ea_v) check(req, "alt_core", int'(alt_core), ea_c);
    @(posedge clk);
    if (rst) model_clear();
    else begin
      if (rv) begin
        reg_n = int'(ra >> 10);
        m_v[reg_n % 16] = 1; m_tag[reg_n % 16] = reg_n / 16; m_core[reg_n % 16] = rc;
        if (!mru_v || rc != mru) begin
          sec_v = mru_v; sec = mru; mru_v = 1; mru = rc;
        end
      end
      if (fv) begin
        reg_n = int'(fa >> 10);
        m_v[reg_n % 16] = 1; m_tag[reg_n % 16] = reg_n / 16; m_core[reg_n % 16] = fc;
      end
    end
  endtask

  task automatic idle(input string req);
    step(0, '0, 0, '0, 0, 0, '0, 0, req);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    rst = 1'b1;
    // R1: misses during reset give nothing
    step(1, mk(0,1,0), 1, mk(0,1,0), 9, 0, '0, 0, "R1");
    step(1, mk(0,1,0), 0, '0, 0, 0, '0, 0, "R1");
    rst = 1'b0;
    step(1, mk(0,1,0), 0, '0, 0, 0, '0, 0, "R1");
    // R4: empty history, no prediction
    step(1, mk(2,5,8), 0, '0, 0, 0, '0, 0, "R4");
    // R9: response and miss in the same cycle see old state
    step(1, mk(1,3,0), 1, mk(1,3,0), 5, 0, '0, 0, "R9");
    // R3: region hit next cycle
    step(1, mk(1,3,4), 0, '0, 0, 0, '0, 0, "R3");
    // R10: other low bits, same entry
    step(1, mk(1,3,1023), 0, '0, 0, 0, '0, 0, "R10");
    // R2: no miss, no output
    idle("R2");
    // R4: other index falls back to most recent
    step(1, mk(1,7,0), 0, '0, 0, 0, '0, 0, "R4");
    // R5/R6: second responder demotes the first
    step(0, '0, 1, mk(1,7,0), 7, 0, '0, 0, "R5");
    step(1, mk(3,9,0), 0, '0, 0, 0, '0, 0, "R6");
    // R5: repeat responder leaves second sharer
    step(0, '0, 1, mk(2,9,0), 7, 0, '0, 0, "R5");
    step(1, mk(3,11,0), 0, '0, 0, 0, '0, 0, "R5");
    // R4: alias on index 3 with different tag
    step(1, mk(2,3,0), 0, '0, 0, 0, '0, 0, "R4");
    // R7: correction rewrites region, sharers unchanged
    step(0, '0, 0, '0, 0, 1, mk(1,3,500), 12, "R7");
    step(1, mk(1,3,0), 0, '0, 0, 0, '0, 0, "R7");
    step(1, mk(4,4,0), 0, '0, 0, 0, '0, 0, "R7");
    // R8: same-entry response and correction, correction wins
    step(0, '0, 1, mk(1,6,0), 2, 1, mk(3,6,9), 14, "R8");
    step(1, mk(3,6,0), 0, '0, 0, 0, '0, 0, "R8");
    step(1, mk(1,6,0), 0, '0, 0, 0, '0, 0, "R8");
    // R1: reset after activity empties everything
    rst = 1'b1;
    idle("R1");
    rst = 1'b0;
    step(1, mk(1,3,0), 0, '0, 0, 0, '0, 0, "R1");
    // mixed phase with heavy aliasing
    for (int n = 0; n < 600; n++) begin
      step($urandom_range(0,3) != 0, mk($urandom_range(0,2), $urandom_range(0,3), $urandom_range(0,1023)),
           $urandom_range(0,1) == 1, mk($urandom_range(0,2), $urandom_range(0,3), $urandom_range(0,1023)),
           $urandom_range(0,15),
           $urandom_range(0,3) == 0, mk($urandom_range(0,2), $urandom_range(0,3), $urandom_range(0,1023)),
           $urandom_range(0,15), "R3_R5_mix");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule